// File: doc/BRIEF.md
# Synchronous Serial Shift Interface

This unit moves one byte at a time over a clocked serial link. A CPU loads a data byte into the shift buffer and writes a mode byte with the start bit set. The unit then clocks eight bits out on the serial data output while it captures eight bits from the serial data input into the same buffer. When the eighth bit is captured the unit stops and raises a completion flag. The shift order can be most-significant or least-significant bit first. A receive-only setting keeps the data output quiet while bits are still captured.

The serial clock has three kinds of source. It can come from an external pin, which passes through a two-flop synchronizer with edge detection. It can come from a toggle signal supplied by a timer. It can also come from one of three internal dividers of the system clock. With an internal source the unit drives the clock pin and asserts the clock output enable. With the external source the pin is released. The CPU may touch the data buffer only while the unit is idle or while the serial clock is high. Outside that window, buffer writes are dropped and buffer reads leave the last read value in place.

Top module: `sio_unit`

## Requirements
- R1: After reset the mode byte is all zeros (external clock, most-significant bit first, receive-only, shifter off), the completion flag is 0, `sckOut` is 1, `sckOe` is 0 and `sout` is 1.
- R2: Mode bit 0 selects the bit order. With 0 the buffer sends bit 7 first and a captured bit enters at bit 0 moving upward (`{buf[6:0],sin}`). With 1 it sends bit 0 first and a captured bit enters at bit 7 (`{sin,buf[7:1]}`).
- R3: Mode bit 1 set to 1 sends buffer data on `sout`. When it is 0, `sout` is held at 1 from the next cycle on, and input bits are still captured.
- R4: Writing the mode byte with bit 3 = 1 clears the completion flag in the next cycle, clears the bit counter and restarts the divider. When bit 2 is also 1, a transfer begins. Bit 3 is never kept, so a later mode write with bit 3 = 0 starts nothing.
- R5: Mode bit 2 is the shifter enable. If a transfer ends with it at 1, the flag is set in the same cycle as the eighth rising edge. A mode write with bit 2 = 0 stops any transfer at once and leaves the flag unchanged.
- R6: Mode bits 7:5 choose the serial clock. 0xx selects the external pin. 100 selects the timer toggle, where each change of `tmrTgl` is one half period. 101, 111 and 110 select the system clock divided by 4, 16 and 1024. Bit 4 is unused and has no effect.
- R7: With an internal source, `sckOe` is 1 and the unit drives `sckOut`. With the external source, `sckOe` is 0 and `sckIn` edges are taken after a two-flop synchronizer.
- R8: `sout` changes on falling serial clock edges and `sin` is sampled on rising edges. After the eighth rising edge the unit halts, and an internally driven `sckOut` stays high.
- R9: CPU buffer writes and reads (`cpuSel` = 1) take effect only while the unit is idle or the serial clock is high. Otherwise a write is ignored and `cpuRData` keeps its previous value. `cpuRData` updates one cycle after an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuSel | input | 1 | Register select: 0 mode byte, 1 data buffer |
| cpuWr | input | 1 | CPU write strobe |
| cpuRd | input | 1 | CPU read strobe (data buffer only) |
| cpuWData | input | 8 | CPU write data |
| cpuRData | output | 8 | Registered buffer read data |
| sckIn | input | 1 | External serial clock pin |
| sckOut | output | 1 | Driven serial clock |
| sckOe | output | 1 | Output enable for the serial clock pin |
| sin | input | 1 | Serial data input |
| sout | output | 1 | Serial data output |
| tmrTgl | input | 1 | Timer toggle clock source |
| irq | output | 1 | Transfer completion flag |

## Verification
The bench loops a known pattern into `sin` and records `sout` on every falling edge, in both bit orders, across every clock source. A mirrored shift direction or a send step placed on the wrong edge would show up as a bit-by-bit mismatch or a wrong final buffer. A buffer write and a read are injected while the clock is low in the middle of a transfer. A design that does not gate this access would corrupt the received byte or update the read data. Further tests cover a flag that is kept when the shifter is disabled, an abort partway through a transfer, a start bit that does not clear itself, and receive-only mode. Each of these faults would show as a flag that is set or cleared at the wrong moment, a transfer that never stops, or data driven when the unit should be listening only.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DATA_W = 8;

  // mode byte layout, bit 7 down to bit 0
  typedef struct packed {
    logic [2:0] clkSel;
    logic       spare;
    logic       start;
    logic       shEn;
    logic       txEn;
    logic       lsbFirst;
  } mode_t;

  localparam logic [2:0] CLK_TMR  = 3'b100;
  localparam logic [2:0] CLK_FAST = 3'b101;
  localparam logic [2:0] CLK_SLOW = 3'b110;
  localparam logic [2:0] CLK_MID  = 3'b111;

  // strobes from control to datapath
  typedef struct packed {
    logic fallStb;
    logic riseStb;
    logic bufWr;
    logic bufRd;
    logic lsbFirst;
    logic txEn;
  } dp_ctrl_t;
endpackage

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 1024,
  parameter int NBITS    = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuSel,
  input  logic       cpuWr,
  input  logic       cpuRd,
  input  logic [7:0] cpuWData,
  input  logic       sckIn,
  input  logic       tmrTgl,
  output logic       sckOut,
  output logic       sckOe,
  output logic       irq,
  output logic       busy,
  output logic       sckHigh,
  output dp_ctrl_t   dpCtl
);
  localparam int HALF_FAST = DIV_FAST / 2;
  localparam int HALF_MID  = DIV_MID / 2;
  localparam int HALF_SLOW = DIV_SLOW / 2;
  localparam int HALF_MAX  = (HALF_SLOW > HALF_MID) ?
                             ((HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST) :
                             ((HALF_MID > HALF_FAST) ? HALF_MID : HALF_FAST);
  localparam int DIVW = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;
  localparam int CNTW = (NBITS > 1) ? $clog2(NBITS) : 1;

  mode_t            modeQ;
  logic             modeWr, startReq, startGo, stopReq;
  logic             extSel, tmrSel, divSel;
  logic [DIVW-1:0]  divCnt, halfLim;
  logic             divTick, halfEvt;
  logic             sckS1, sckS2, sckS3;
  logic             extRise, extFall, intRise, intFall;
  logic             tmrPrev, tmrEvt;
  logic             sckLvl;
  logic [CNTW-1:0]  bitCnt;
  logic             riseStb, fallStb, lastBit, access;

  assign modeWr   = cpuWr && !cpuSel;
  assign startReq = modeWr && cpuWData[3];
  assign startGo  = startReq && cpuWData[2];
  assign stopReq  = modeWr && !cpuWData[2];

  // mode register: start and spare never stored
  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= '0;
    else if (modeWr) begin
      modeQ       <= mode_t'(cpuWData);
      modeQ.start <= 1'b0;
      modeQ.spare <= 1'b0;
    end
  end

  // clock source decode
  assign extSel = !modeQ.clkSel[2];
  assign tmrSel = (modeQ.clkSel == CLK_TMR);
  assign divSel = modeQ.clkSel[2] && (modeQ.clkSel[1:0] != 2'b00);

  always_comb begin
    unique case (modeQ.clkSel)
      CLK_FAST: halfLim = DIVW'(HALF_FAST - 1);
      CLK_MID:  halfLim = DIVW'(HALF_MID - 1);
      CLK_SLOW: halfLim = DIVW'(HALF_SLOW - 1);
      default:  halfLim = '0;
    endcase
  end

  assign divTick = busy && divSel && (divCnt == halfLim);

  always_ff @(posedge clk) begin
    if (!rstN || !busy || startReq || divTick) divCnt <= '0;
    else if (divSel) divCnt <= divCnt + 1'b1;
  end

  // external clock synchronizer and edge detect
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckS1 <= 1'b1;
      sckS2 <= 1'b1;
      sckS3 <= 1'b1;
    end else begin
      sckS1 <= sckIn;
      sckS2 <= sckS1;
      sckS3 <= sckS2;
    end
  end
  assign extRise = sckS2 && !sckS3;
  assign extFall = !sckS2 && sckS3;

  // timer toggle change detect
  always_ff @(posedge clk) begin
    if (!rstN) tmrPrev <= 1'b0;
    else tmrPrev <= tmrTgl;
  end
  assign tmrEvt = tmrTgl ^ tmrPrev;

  assign halfEvt = busy && (tmrSel ? tmrEvt : divTick);

  // internal serial clock level, idle high
  always_ff @(posedge clk) begin
    if (!rstN || !busy || startReq) sckLvl <= 1'b1;
    else if (halfEvt) sckLvl <= !sckLvl;
  end
  assign intRise = halfEvt && !sckLvl;
  assign intFall = halfEvt && sckLvl;

  assign riseStb = busy && !modeWr && (extSel ? extRise : intRise);
  assign fallStb = busy && !modeWr && (extSel ? extFall : intFall);
  assign lastBit = riseStb && (bitCnt == CNTW'(NBITS - 1));

  // bit counter
  always_ff @(posedge clk) begin
    if (!rstN || startReq) bitCnt <= '0;
    else if (riseStb) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
  end

  // run state
  always_ff @(posedge clk) begin
    if (!rstN) busy <= 1'b0;
    else if (startGo) busy <= 1'b1;
    else if (stopReq || lastBit) busy <= 1'b0;
  end

  // completion flag
  always_ff @(posedge clk) begin
    if (!rstN || startReq) irq <= 1'b0;
    else if (lastBit && modeQ.shEn) irq <= 1'b1;
  end

  assign sckHigh = extSel ? sckS3 : sckLvl;
  assign access  = !busy || sckHigh;

  assign sckOut = extSel ? 1'b1 : sckLvl;
  assign sckOe  = !extSel;

  always_comb begin
    dpCtl.fallStb  = fallStb;
    dpCtl.riseStb  = riseStb;
    dpCtl.bufWr    = cpuWr && cpuSel && access;
    dpCtl.bufRd    = cpuRd && cpuSel && access;
    dpCtl.lsbFirst = modeQ.lsbFirst;
    dpCtl.txEn     = modeQ.txEn;
  end
endmodule

// File: rtl/sio_datapath.sv
module sio_datapath
  import sio_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_ctrl_t         dpCtl,
  input  logic [NBITS-1:0] cpuWData,
  input  logic             sin,
  output logic             sout,
  output logic [NBITS-1:0] rdData,
  output logic [NBITS-1:0] bufQ
);
  logic [NBITS-1:0] shifted;
  logic             headBit;

  generate
    if (NBITS > 1) begin : g_wide
      assign shifted = dpCtl.lsbFirst ? {sin, bufQ[NBITS-1:1]}
                                      : {bufQ[NBITS-2:0], sin};
    end else begin : g_narrow
      assign shifted = sin;
    end
  endgenerate

  assign headBit = dpCtl.lsbFirst ? bufQ[0] : bufQ[NBITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) bufQ <= '0;
    else if (dpCtl.riseStb) bufQ <= shifted;
    else if (dpCtl.bufWr) bufQ <= cpuWData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !dpCtl.txEn) sout <= 1'b1;
    else if (dpCtl.fallStb) sout <= headBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (dpCtl.bufRd) rdData <= bufQ;
  end
endmodule

// File: rtl/sio_unit.sv
module sio_unit
  import sio_pkg::*;
#(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuSel,
  input  logic       cpuWr,
  input  logic       cpuRd,
  input  logic [7:0] cpuWData,
  output logic [7:0] cpuRData,
  input  logic       sckIn,
  output logic       sckOut,
  output logic       sckOe,
  input  logic       sin,
  output logic       sout,
  input  logic       tmrTgl,
  output logic       irq
);
  dp_ctrl_t    dpCtl;
  logic        busy, sckHigh;
  logic [7:0]  bufQ;

  sio_ctrl #(
    .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW), .NBITS(DATA_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .cpuWData(cpuWData), .sckIn(sckIn), .tmrTgl(tmrTgl), .sckOut(sckOut),
    .sckOe(sckOe), .irq(irq), .busy(busy), .sckHigh(sckHigh), .dpCtl(dpCtl)
  );

  sio_datapath #(.NBITS(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .cpuWData(cpuWData), .sin(sin),
    .sout(sout), .rdData(cpuRData), .bufQ(bufQ)
  );
endmodule

// File: rtl/sio_unit_chk.sv
module sio_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cpuSel,
  input logic       cpuWr,
  input logic [7:0] cpuWData,
  input logic       irq,
  input logic       sckOut,
  input logic       sckOe,
  input logic       sout,
  input logic       busy,
  input logic       sckHigh,
  input logic       riseStb,
  input logic       txEn,
  input logic [7:0] bufQ
);
  // R4
  start_clears_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && !cpuSel && cpuWData[3]) |=> !irq);

  // R5
  flag_rises_at_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(busy) && !busy));

  // R8
  idle_clock_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && sckOe) |-> sckOut);

  // R9
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !sckHigh && cpuWr && cpuSel && !riseStb) |=> (bufQ == $past(bufQ)));

  // R3
  rx_only_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> sout);
endmodule

bind sio_unit sio_unit_chk chk_i (
  .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuWData(cpuWData),
  .irq(irq), .sckOut(sckOut), .sckOe(sckOe), .sout(sout), .busy(busy),
  .sckHigh(sckHigh), .riseStb(dpCtl.riseStb), .txEn(dpCtl.txEn), .bufQ(bufQ)
);

// File: tb/sio_unit_tb.sv
module sio_unit_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuSel = 1'b0, cpuWr = 1'b0, cpuRd = 1'b0;
  logic [7:0] cpuWData = '0;
  logic [7:0] cpuRData;
  logic       sckIn = 1'b1, sin = 1'b0, tmrTgl = 1'b0, tmrRun = 1'b0;
  logic       sckOut, sckOe, sout, irq;
  int         vecCnt = 0, errCnt = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  sio_unit dut_i (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .cpuWData(cpuWData), .cpuRData(cpuRData), .sckIn(sckIn), .sckOut(sckOut),
    .sckOe(sckOe), .sin(sin), .sout(sout), .tmrTgl(tmrTgl), .irq(irq)
  );

  // timer toggle source
  initial forever begin
    repeat (3) @(negedge clk);
    if (tmrRun) tmrTgl = ~tmrTgl;
  end

  function automatic logic [7:0] modeByte(input logic [2:0] src, input logic start,
                                          input logic shEn, input logic tx, input logic lsb);
    return {src, 1'b0, start, shEn, tx, lsb};
  endfunction

  // bit k of a transfer in the selected order (R2)
  function automatic logic orderBit(input logic [7:0] v, input int k, input logic lsb);
    return lsb ? v[k] : v[7-k];
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic sel, input logic [7:0] d);
    cpuSel = sel; cpuWData = d; cpuWr = 1'b1;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic cpuRead(output logic [7:0] d);
    cpuSel = 1'b1; cpuRd = 1'b1;
    @(negedge clk);
    cpuRd = 1'b0;
    d = cpuRData;
  endtask

  task automatic waitSck(input logic lvl, input string req);
    int n = 0;
    while (sckOut !== lvl && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) chk(req, "serial clock timeout", {7'd0, sckOut}, {7'd0, lvl});
  endtask

  // one full transfer with bench-driven sin and checks on sout, buffer, flag
  task automatic runXfer(input logic [2:0] src, input logic lsb, input logic tx,
                         input logic [7:0] txData, input logic [7:0] pat, input logic inject);
    logic [7:0] rd, staleRd;
    logic       got;
    cpuWrite(1'b1, txData);
    cpuRead(staleRd);
    cpuWrite(1'b0, modeByte(src, 1'b1, 1'b1, tx, lsb));
    for (int k = 0; k < 8; k++) begin
      if (!src[2]) begin
        sckIn = 1'b0;
        repeat (6) @(negedge clk);
        got = sout;
        sin = orderBit(pat, k, lsb);
        repeat (2) @(negedge clk);
        sckIn = 1'b1;
        repeat (8) @(negedge clk);
      end else begin
        waitSck(1'b0, "R8");
        got = sout;
        sin = orderBit(pat, k, lsb);
        if (inject && k == 3) begin
          cpuWrite(1'b1, 8'h3C);
          cpuRead(rd);
          chk("R9", "read during low phase stays stale", rd, staleRd);
        end
        waitSck(1'b1, "R8");
      end
      // R2 R3 sent bit per position
      chk(tx ? "R2" : "R3", "sout bit", {7'd0, got},
          {7'd0, tx ? orderBit(txData, k, lsb) : 1'b1});
    end
    repeat (2) @(negedge clk);
    chk("R5", "flag after completion", {7'd0, irq}, 8'd1);
    chk("R8", "clock idle high after halt", {7'd0, sckOut}, 8'd1);
    cpuRead(rd);
    chk("R2", "received buffer", rd, pat);
  endtask

  initial begin
    logic [7:0] rd;
    int lows;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "irq", {7'd0, irq}, 8'd0);
    chk("R1", "sckOut", {7'd0, sckOut}, 8'd1);
    chk("R1", "sckOe", {7'd0, sckOe}, 8'd0);
    chk("R1", "sout", {7'd0, sout}, 8'd1);
    cpuRead(rd);
    chk("R1", "buffer", rd, 8'h00);

    // directed loopback in both orders, divide by 4
    runXfer(3'b101, 1'b0, 1'b1, 8'hB4, 8'h96, 1'b0);
    chk("R7", "sckOe internal", {7'd0, sckOe}, 8'd1);
    runXfer(3'b101, 1'b1, 1'b1, 8'hB4, 8'h1E, 1'b0);

    // R6 divide by 16 with blocked access injection (R9)
    runXfer(3'b111, 1'b0, 1'b1, 8'hC3, 8'h5A, 1'b1);
    // R6 divide by 1024
    runXfer(3'b110, 1'b1, 1'b1, 8'h81, 8'h7E, 1'b0);
    // R6 timer toggle source
    tmrRun = 1'b1;
    runXfer(3'b100, 1'b0, 1'b1, 8'h2D, 8'hE1, 1'b0);
    tmrRun = 1'b0;
    // R7 external clock, both orders
    runXfer(3'b000, 1'b0, 1'b1, 8'h6C, 8'hA3, 1'b0);
    chk("R7", "sckOe external", {7'd0, sckOe}, 8'd0);
    chk("R7", "sckOut released high", {7'd0, sckOut}, 8'd1);
    runXfer(3'b011, 1'b1, 1'b1, 8'h6C, 8'h3A, 1'b0);
    // R3 receive-only
    runXfer(3'b101, 1'b0, 1'b0, 8'h00, 8'hC9, 1'b0);

    // R5 flag retained when shifter disabled without start
    cpuWrite(1'b0, modeByte(3'b101, 1'b0, 1'b0, 1'b1, 1'b0));
    repeat (3) @(negedge clk);
    chk("R5", "flag kept with shifter off", {7'd0, irq}, 8'd1);

    // R4 no start bit: nothing runs, flag kept
    cpuWrite(1'b0, modeByte(3'b101, 1'b0, 1'b1, 1'b1, 1'b0));
    lows = 0;
    for (int i = 0; i < 60; i++) begin
      if (sckOut == 1'b0) lows++;
      @(negedge clk);
    end
    chk("R4", "no clock without start", lows[7:0], 8'd0);
    chk("R4", "flag kept without start", {7'd0, irq}, 8'd1);

    // R4 start clears flag; R5 abort mid-transfer keeps flag clear
    cpuWrite(1'b1, 8'hFF);
    cpuWrite(1'b0, modeByte(3'b101, 1'b1, 1'b1, 1'b1, 1'b0));
    chk("R4", "flag cleared by start", {7'd0, irq}, 8'd0);
    for (int k = 0; k < 3; k++) begin
      waitSck(1'b0, "R5");
      waitSck(1'b1, "R5");
    end
    cpuWrite(1'b0, modeByte(3'b101, 1'b0, 1'b0, 1'b1, 1'b0));
    lows = 0;
    for (int i = 0; i < 50; i++) begin
      if (sckOut == 1'b0) lows++;
      @(negedge clk);
    end
    chk("R5", "abort stops clock", lows[7:0], 8'd0);
    chk("R5", "abort leaves flag clear", {7'd0, irq}, 8'd0);

    // constrained random transfers
    for (int t = 0; t < 8; t++) begin
      logic [2:0] src;
      logic [7:0] d, p;
      int sel;
      sel = $urandom_range(0, 2);
      src = (sel == 0) ? 3'b101 : (sel == 1) ? 3'b111 : 3'b100;
      d = 8'($urandom);
      p = 8'($urandom);
      tmrRun = (src == 3'b100);
      runXfer(src, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), d, p, 1'b0);
      tmrRun = 1'b0;
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  // watchdog
  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      vecCnt++;
      errCnt++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end
endmodule